// File: doc/BRIEF.md
# Host Packet-DMA Command Sequencer

This block runs the host side of one packet command whose data moves by DMA over a parallel ATA-style task-file interface. It starts once software has issued the PACKET opcode. It waits out the settle time the device needs and then polls status. When the device asks for the command packet, it writes the packet one 16-bit word per cycle. It then waits for an interrupt or a DMA request and hands the data phase to an external DMA engine. Finally it ends the command with an exit code. The code tells the surrounding host logic what to do next: return to idle, finish a queued command, follow a bus release, or issue a service command.

Status arrives already decoded as single bits. A status read takes one cycle: the block raises its status-read strobe, and the bits present in that cycle are the ones it acts on. Waits given in nanoseconds are turned into clock cycles, rounded up, using the clock-period parameter. With the defaults (8 ns clock, 400 ns settle time, 120 ns PIO cycle, 12-byte packet) the settle wait is 50 cycles, the PIO wait is 15 cycles and the packet is 6 words.

Top module: `pkt_dma_seq`

## Requirements
- R1: During and right after reset the block is idle. No strobe is active, `busy` and `done` are low, and `exit_code` is 0.
- R2: After `cmd_start` is taken in idle, the first status read comes exactly SETTLE_CYC+1 cycles later (51 with the defaults). No status read happens before then.
- R3: In the first status phase, BSY=1 repeats the status read every cycle. BSY=0 with DRQ=1 starts the packet. BSY, DRQ, REL and SERV all 0 ends the command with exit code 1 (idle).
- R4: The packet is written as exactly WORDS consecutive `data_wr` cycles, with `pkt_word` counting 0 up to WORDS-1.
- R5: After the last packet word with nIEN=1, `alt_rd` pulses for one cycle and the next status read comes PIO_CYC+1 cycles after that word (16 with the defaults). With nIEN=0 the block waits and makes no status read or data write.
- R6: In the second status phase, BSY=1 keeps polling, and BSY=0 with DRQ=1 also keeps polling unless DMARQ=1 and nIEN=1. In that case `dma_en` rises in the next cycle.
- R7: In the second status phase, BSY=0 and DRQ=0 end the command with a code. SERV=1 gives 6 (service) and has the highest priority. Otherwise REL=1 gives 4 if nIEN=0 or 5 if nIEN=1. Otherwise a non-empty queue gives 2 if nIEN=0 or 3 if nIEN=1. Otherwise the code is 1 (idle).
- R8: While waiting, DMARQ=1 moves the block straight to data transfer. INTRQ=1 with nIEN=0 gives a status read in the next cycle, with no PIO wait. INTRQ=1 with nIEN=1 is ignored.
- R9: In data transfer, `dma_term`, or `dma_done` with nIEN=1, drops `dma_en` and gives `alt_rd` and the PIO wait before the next status read. `dma_done` with nIEN=0 drops `dma_en` and returns to waiting with no status read.
- R10: If any status read of the current command saw REL=1, `tag_rd` pulses in the first data-transfer cycle only. Otherwise it never pulses.
- R11: `done` is a one-cycle pulse. `exit_err` equals the ERR bit of the status read that ended the command. Both `exit_code` and `exit_err` hold until the next `cmd_start` clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | PACKET opcode has just been issued |
| st_bsy | input | 1 | Status BSY bit |
| st_drq | input | 1 | Status DRQ bit |
| st_rel | input | 1 | Status bus-release bit |
| st_serv | input | 1 | Status service bit |
| st_err | input | 1 | Status error bit |
| intrq | input | 1 | Device interrupt request |
| dmarq | input | 1 | Device DMA request |
| nien | input | 1 | Interrupts disabled by host |
| queue_pending | input | 1 | Device holds released queued commands |
| dma_done | input | 1 | DMA engine moved all data |
| dma_term | input | 1 | DMA burst ended before all data moved |
| stat_rd | output | 1 | Status register read strobe |
| alt_rd | output | 1 | Dummy alternate-status read strobe |
| data_wr | output | 1 | Data register write strobe for a packet word |
| pkt_word | output | IW | Index of the packet word being written |
| dma_en | output | 1 | DMA engine owns the data port |
| tag_rd | output | 1 | Sector-count read for the queued tag |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command finished this cycle |
| exit_code | output | 3 | Exit code: 1 idle, 2/3 queued complete, 4/5 released, 6 service |
| exit_err | output | 1 | ERR was set in the final status read |

## Verification
The hardest case to reach from the ports is the tag read. It needs a REL bit seen in an early status read, and then a data transfer entered from the interrupt wait in the same command. The stimulus gets there by holding BSY with REL set during the first polls, clearing REL, sending the packet with nIEN=0, and then raising DMARQ. Two other paths also take planned input ordering: the masked-interrupt path, where nIEN changes while the block waits, and a transfer that ends early with `dma_term` and then runs a full PIO wait.

// File: rtl/pds_pkg.sv
// Shared types and helpers for the packet-DMA sequencer.
// Assumes: cycle conversion rounds up and never yields less than one cycle.
package pds_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_SETTLE, S_CHK_A, S_SEND, S_PIO_WAIT,
        S_CHK_B, S_IRQ_WAIT, S_XFER, S_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        EX_NONE       = 3'd0,
        EX_IDLE       = 3'd1,
        EX_QDONE_IRQ  = 3'd2,
        EX_QDONE_POLL = 3'd3,
        EX_REL_IRQ    = 3'd4,
        EX_REL_POLL   = 3'd5,
        EX_SERVICE    = 3'd6
    } exit_t;

    // Nanoseconds to whole clock cycles, rounded up, at least one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/pds_timer.sv
// Loadable down-counter used for the settle and PIO waits.
// Assumes: load has priority; expired is high while the count is zero.
module pds_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load a new wait length or count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pds_word_ctr.sv
// Packet word index counter; saturates at the last word.
// Assumes: clear and step are never asserted together.
module pds_word_ctr #(
    parameter int WORDS = 6,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [IW-1:0] idx,
    output logic          last
);
    // Advance one word per step, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx <= '0;
        else if (clear)            idx <= '0;
        else if (step && !last)    idx <= idx + 1'b1;
    end

    assign last = (idx == IW'(WORDS - 1));
endmodule

// File: rtl/pds_status_decode.sv
// Decodes one status read into the next action of a status-check phase.
// Assumes: phase_b selects the post-packet check; the outputs are only used
// in a cycle where the status-read strobe is high.
module pds_status_decode
    import pds_pkg::*;
(
    input  logic  phase_b,
    input  logic  bsy,
    input  logic  drq,
    input  logic  rel,
    input  logic  serv,
    input  logic  dmarq,
    input  logic  nien,
    input  logic  queue_pending,
    output logic  go_send,
    output logic  go_xfer,
    output logic  go_exit,
    output exit_t code
);
    // Priority decode of status bits into send, transfer or an exit code.
    always_comb begin
        go_send = 1'b0;
        go_xfer = 1'b0;
        go_exit = 1'b0;
        code    = EX_NONE;
        if (!bsy) begin
            if (!phase_b) begin
                if (drq) begin
                    go_send = 1'b1;
                end else if (!rel && !serv) begin
                    go_exit = 1'b1;
                    code    = EX_IDLE;
                end
            end else if (drq) begin
                go_xfer = dmarq && nien;
            end else begin
                go_exit = 1'b1;
                if (serv)               code = EX_SERVICE;
                else if (rel)           code = nien ? EX_REL_POLL : EX_REL_IRQ;
                else if (queue_pending) code = nien ? EX_QDONE_POLL : EX_QDONE_IRQ;
                else                    code = EX_IDLE;
            end
        end
    end
endmodule

// File: rtl/pkt_dma_seq.sv
// Host sequencer for one packet command with DMA data phase.
// Assumes: status bits are valid in the cycle stat_rd is high; the DMA engine
// is armed by the host before the device raises DMARQ; one command at a time.
module pkt_dma_seq
    import pds_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int SETTLE_NS     = 400,
    parameter int PIO_CYCLE_NS  = 120,
    parameter int PKT_BYTES     = 12,
    localparam int WORDS        = (PKT_BYTES + 1) / 2,
    localparam int IW           = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          st_bsy,
    input  logic          st_drq,
    input  logic          st_rel,
    input  logic          st_serv,
    input  logic          st_err,
    input  logic          intrq,
    input  logic          dmarq,
    input  logic          nien,
    input  logic          queue_pending,
    input  logic          dma_done,
    input  logic          dma_term,
    output logic          stat_rd,
    output logic          alt_rd,
    output logic          data_wr,
    output logic [IW-1:0] pkt_word,
    output logic          dma_en,
    output logic          tag_rd,
    output logic          busy,
    output logic          done,
    output logic [2:0]    exit_code,
    output logic          exit_err
);
    localparam int SETTLE_CYC = ns_to_cycles(SETTLE_NS, PIO_CYCLE_NS > 0 ? CLK_PERIOD_NS : 1);
    localparam int PIO_CYC    = ns_to_cycles(PIO_CYCLE_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC    = (SETTLE_CYC > PIO_CYC) ? SETTLE_CYC : PIO_CYC;
    localparam int TW         = $clog2(MAX_CYC + 1);

    seq_state_t     state_q, state_d;
    logic           entry_q, released_q;
    exit_t          exit_q;
    logic           err_q;
    logic           tmr_load, tmr_expired;
    logic [TW-1:0]  tmr_val;
    logic           ctr_clear, ctr_step, word_last;
    logic           go_send, go_xfer, go_exit;
    exit_t          dec_code;

    pds_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_expired)
    );

    pds_word_ctr #(.WORDS(WORDS), .IW(IW)) u_words (
        .clk(clk), .rst_n(rst_n), .clear(ctr_clear),
        .step(ctr_step), .idx(pkt_word), .last(word_last)
    );

    pds_status_decode u_decode (
        .phase_b(state_q == S_CHK_B), .bsy(st_bsy), .drq(st_drq),
        .rel(st_rel), .serv(st_serv), .dmarq(dmarq), .nien(nien),
        .queue_pending(queue_pending), .go_send(go_send),
        .go_xfer(go_xfer), .go_exit(go_exit), .code(dec_code)
    );

    // Next-state selection together with timer and word-counter controls.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ctr_clear = 1'b0;
        ctr_step  = 1'b0;
        case (state_q)
            S_IDLE: if (cmd_start) begin
                state_d  = S_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE_CYC - 1);
            end
            S_SETTLE: if (tmr_expired) state_d = S_CHK_A;
            S_CHK_A: begin
                if (go_send) begin
                    state_d   = S_SEND;
                    ctr_clear = 1'b1;
                end else if (go_exit) begin
                    state_d = S_DONE;
                end
            end
            S_SEND: begin
                if (!word_last) begin
                    ctr_step = 1'b1;
                end else if (nien) begin
                    state_d  = S_PIO_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PIO_CYC - 1);
                end else begin
                    state_d = S_IRQ_WAIT;
                end
            end
            S_PIO_WAIT: if (tmr_expired) state_d = S_CHK_B;
            S_CHK_B: begin
                if (go_xfer)      state_d = S_XFER;
                else if (go_exit) state_d = S_DONE;
            end
            S_IRQ_WAIT: begin
                if (dmarq)               state_d = S_XFER;
                else if (intrq && !nien) state_d = S_CHK_B;
            end
            S_XFER: begin
                if ((dma_done && nien) || (!dma_done && dma_term)) begin
                    state_d  = S_PIO_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PIO_CYC - 1);
                end else if (dma_done) begin
                    state_d = S_IRQ_WAIT;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and one-cycle state-entry marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            entry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            entry_q <= (state_d != state_q);
        end
    end

    // Remember whether any status read of this command reported a bus release.
    always_ff @(posedge clk) begin
        if (!rst_n)                             released_q <= 1'b0;
        else if (state_q == S_IDLE && cmd_start) released_q <= 1'b0;
        else if (stat_rd && st_rel)             released_q <= 1'b1;
    end

    // Capture exit code and error on completion; clear them on a new command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_q <= EX_NONE;
            err_q  <= 1'b0;
        end else if (state_q == S_IDLE && cmd_start) begin
            exit_q <= EX_NONE;
            err_q  <= 1'b0;
        end else if (state_d == S_DONE && state_q != S_DONE) begin
            exit_q <= dec_code;
            err_q  <= st_err;
        end
    end

    assign stat_rd   = (state_q == S_CHK_A) || (state_q == S_CHK_B);
    assign alt_rd    = (state_q == S_PIO_WAIT) && entry_q;
    assign data_wr   = (state_q == S_SEND);
    assign dma_en    = (state_q == S_XFER);
    assign tag_rd    = (state_q == S_XFER) && entry_q && released_q;
    assign busy      = (state_q != S_IDLE) && (state_q != S_DONE);
    assign done      = (state_q == S_DONE);
    assign exit_code = exit_q;
    assign exit_err  = err_q;
endmodule

// File: rtl/pkt_dma_seq_chk.sv
// Property checker for the packet-DMA sequencer, bound to every instance.
// Assumes: observes ports only.
module pkt_dma_seq_chk #(
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dmarq,
    input logic          stat_rd,
    input logic          alt_rd,
    input logic          data_wr,
    input logic [IW-1:0] pkt_word,
    input logic          dma_en,
    input logic          tag_rd,
    input logic          busy,
    input logic          done,
    input logic [2:0]    exit_code
);
    AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !stat_rd); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({stat_rd, alt_rd, data_wr, tag_rd}) <= 1); // R5
    AST_WORDS_CONSEC: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && pkt_word != '0) |-> $past(data_wr)); // R4
    AST_XFER_NEEDS_DMARQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_en) |-> $past(dmarq)); // R6
    AST_TAG_FIRST_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        tag_rd |-> $rose(dma_en)); // R10
    AST_CODE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> exit_code != 3'd0); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R11
endmodule

bind pkt_dma_seq pkt_dma_seq_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dmarq(dmarq), .stat_rd(stat_rd),
    .alt_rd(alt_rd), .data_wr(data_wr), .pkt_word(pkt_word),
    .dma_en(dma_en), .tag_rd(tag_rd), .busy(busy), .done(done),
    .exit_code(exit_code)
);

// File: tb/pkt_dma_seq_tb.sv
// Scoreboard bench: tasks push expected exits, a monitor compares on done.
module pkt_dma_seq_tb;
    localparam int SETTLE_CYC = 50;   // 400 ns at 8 ns
    localparam int PIO_CYC    = 15;   // 120 ns at 8 ns
    localparam int WORDS      = 6;    // 12-byte packet

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, st_bsy = 0, st_drq = 0, st_rel = 0, st_serv = 0, st_err = 0;
    logic intrq = 0, dmarq = 0, nien = 1, queue_pending = 0, dma_done = 0, dma_term = 0;
    logic stat_rd, alt_rd, data_wr, dma_en, tag_rd, busy, done, exit_err;
    logic [2:0] pkt_word;
    logic [2:0] exit_code;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct { int code; int err; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    pkt_dma_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .st_bsy(st_bsy),
        .st_drq(st_drq), .st_rel(st_rel), .st_serv(st_serv), .st_err(st_err),
        .intrq(intrq), .dmarq(dmarq), .nien(nien), .queue_pending(queue_pending),
        .dma_done(dma_done), .dma_term(dma_term), .stat_rd(stat_rd),
        .alt_rd(alt_rd), .data_wr(data_wr), .pkt_word(pkt_word),
        .dma_en(dma_en), .tag_rd(tag_rd), .busy(busy), .done(done),
        .exit_code(exit_code), .exit_err(exit_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_exit(input int code, input int err);
        exp_t e;
        e.code = code;
        e.err  = err;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each completion against the oldest expected exit.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected completion", exit_code, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(exit_code == e.code, "R7 exit code", exit_code, e.code);
                chk(exit_err == e.err, "R11 error flag", exit_err, e.err);
            end
        end
    end

    task automatic begin_cmd(output int n);
        @(negedge clk);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        n = 1;
        while (!stat_rd && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic send_packet(input bit nien_v);
        int n;
        nien   = nien_v;
        st_bsy = 1'b0;
        st_drq = 1'b1;
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            chk(data_wr && pkt_word == 3'(i), "R4 packet word", pkt_word, i);
        end
        st_drq = 1'b0;
        st_bsy = 1'b1;
        if (nien_v) begin
            @(negedge clk);
            chk(alt_rd, "R5 alt status read", alt_rd, 1);
            n = 1;
            while (!stat_rd && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(n == PIO_CYC + 1, "R5 PIO wait", n, PIO_CYC + 1);
        end else begin
            repeat (10) begin
                @(negedge clk);
                chk(!stat_rd && !data_wr, "R5 interrupt wait quiet", stat_rd, 0);
            end
        end
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 10);
        chk(done, "R11 completion pulse", done, 1);
        @(negedge clk);
    endtask

    task automatic run_exit(input bit nv, input bit q, input bit rel, input bit serv,
                            input bit err, input int code);
        int n;
        st_bsy = 1'b1;
        begin_cmd(n);
        send_packet(nv);
        if (!nv) begin
            intrq = 1'b1;
            @(negedge clk);
            chk(stat_rd, "R8 interrupt to status", stat_rd, 1);
            intrq = 1'b0;
        end
        st_bsy = 1'b0;
        queue_pending = q;
        st_rel = rel;
        st_serv = serv;
        st_err = err;
        expect_exit(code, err);
        wait_done();
        queue_pending = 0; st_rel = 0; st_serv = 0; st_err = 0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(!stat_rd && !data_wr && !busy && !done && exit_code == 0, "R1 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !stat_rd && !dma_en && exit_code == 0, "R1 idle after reset", exit_code, 0);

        // Settle wait, polling, idle exit with error from first check
        st_bsy = 1'b1;
        begin_cmd(n);
        chk(n == SETTLE_CYC + 1, "R2 settle before first read", n, SETTLE_CYC + 1);
        repeat (3) begin
            @(negedge clk);
            chk(stat_rd && busy, "R3 BSY keeps polling", stat_rd, 1);
        end
        st_bsy = 1'b0;
        st_err = 1'b1;
        expect_exit(1, 1);
        wait_done();
        st_err = 1'b0;
        repeat (3) @(negedge clk);
        chk(exit_code == 1 && exit_err && !busy, "R11 exit held", exit_code, 1);

        // Full DMA path ended by early termination, queued completion polled
        st_bsy = 1'b1;
        begin_cmd(n);
        chk(exit_code == 0 && !exit_err, "R11 cleared on start", exit_code, 0);
        send_packet(1'b1);
        repeat (2) begin
            @(negedge clk);
            chk(stat_rd, "R6 BSY polling", stat_rd, 1);
        end
        st_bsy = 1'b0;
        st_drq = 1'b1;
        @(negedge clk);
        chk(stat_rd && !dma_en, "R6 DRQ without DMARQ polls", dma_en, 0);
        dmarq = 1'b1;
        @(negedge clk);
        chk(dma_en, "R6 transfer starts", dma_en, 1);
        chk(!tag_rd, "R10 no tag without release", tag_rd, 0);
        dmarq = 1'b0;
        st_drq = 1'b0;
        st_bsy = 1'b1;
        @(negedge clk);
        chk(dma_en, "R9 transfer holds", dma_en, 1);
        dma_term = 1'b1;
        @(negedge clk);
        dma_term = 1'b0;
        chk(alt_rd && !dma_en, "R9 burst end to PIO wait", alt_rd, 1);
        n = 1;
        while (!stat_rd && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == PIO_CYC + 1, "R9 PIO wait after transfer", n, PIO_CYC + 1);
        st_bsy = 1'b0;
        queue_pending = 1'b1;
        expect_exit(3, 0);
        wait_done();
        queue_pending = 1'b0;

        // Interrupt wait: masked INTRQ ignored, service wins over release
        st_bsy = 1'b1;
        begin_cmd(n);
        send_packet(1'b0);
        nien = 1'b1;
        intrq = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(!stat_rd && !dma_en, "R8 masked INTRQ ignored", stat_rd, 0);
        end
        nien = 1'b0;
        @(negedge clk);
        chk(stat_rd, "R8 INTRQ gives status read", stat_rd, 1);
        intrq = 1'b0;
        st_bsy = 1'b0;
        st_rel = 1'b1;
        st_serv = 1'b1;
        expect_exit(6, 0);
        wait_done();
        st_rel = 1'b0;
        st_serv = 1'b0;

        // Released bus: tag read on DMARQ from wait, done with nIEN=0
        st_bsy = 1'b1;
        st_rel = 1'b1;
        begin_cmd(n);
        @(negedge clk);
        st_rel = 1'b0;
        send_packet(1'b0);
        dmarq = 1'b1;
        @(negedge clk);
        chk(dma_en && tag_rd, "R10 tag read on entry", tag_rd, 1);
        dmarq = 1'b0;
        @(negedge clk);
        chk(dma_en && !tag_rd, "R10 single tag read", tag_rd, 0);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
        chk(!dma_en && !stat_rd && !alt_rd, "R9 done to interrupt wait", stat_rd, 0);
        repeat (3) begin
            @(negedge clk);
            chk(!stat_rd, "R9 no status in wait", stat_rd, 0);
        end
        st_bsy = 1'b0;
        st_rel = 1'b1;
        intrq = 1'b1;
        expect_exit(4, 0);
        wait_done();
        intrq = 1'b0;
        st_rel = 1'b0;

        // Remaining exit codes from the second check
        run_exit(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1);
        run_exit(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2);
        run_exit(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5);
        run_exit(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);

        chk(exp_q.size() == 0, "R7 all exits seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule